// File: doc/BRIEF.md
# Doorbell Command Queue Manager

This block drains a cyclic ring of command-buffer descriptors. Software fills ring slots through a write port and then writes a new producer index to the doorbell. Whenever the producer and consumer indices differ, the engine reads the descriptor at its consumer index and passes the buffer address and byte length to a downstream executor over a valid/ready request. It then waits for a done pulse from that executor.

When the done pulse arrives, the engine stores a completion record in a separate completion ring, advances its consumer index and completion write pointer, and raises a one-cycle interrupt in the next cycle. The interrupt therefore never comes before its record can be read. Both rings are internal memories. Software reads the completion ring through a read port and can watch both indices and a sticky doorbell-error flag.

Top module: `cmdq_engine`

## Requirements
- R1: While reset is asserted, the producer index, consumer index and completion write pointer read 0, the doorbell-error flag is 0, and neither the request valid nor the interrupt is high.
- R2: A doorbell write that is accepted loads the written value as the producer index. The engine issues no request while the producer index equals the consumer index, and it starts work when they differ.
- R3: A descriptor is 128 bits: bits 63:0 are the buffer address, bits 95:64 are the length, and bits 127:96 are ignored. The request presents exactly that address and length.
- R4: Once a request is valid, it stays valid with an unchanged address and length until ready is sampled high.
- R5: After a request is accepted, the engine waits for done. Until done arrives, the consumer index does not move and no interrupt is raised.
- R6: After done, the engine writes the completion record at the completion write pointer. The record is 64 bits: the length in bits 63:32 and the finished descriptor's consumer index, zero-extended, in bits 31:0. The pointer then advances by one modulo the completion depth.
- R7: The interrupt is a single-cycle pulse. It arrives one cycle after the completion record is written, and that record is already readable in the interrupt cycle.
- R8: The consumer index advances by exactly one per finished descriptor and wraps modulo the ring depth, so descriptors are served in ring order.
- R9: A doorbell may make up to depth−1 entries pending, which fills the ring while one slot stays unused.
- R10: A doorbell write whose value would make fewer entries pending than are pending now is ignored. It leaves the producer index unchanged and sets the error flag, which stays set until reset.
- R11: A doorbell write in the same cycle as a consumer-index advance is judged against the consumer index before the advance. If accepted, the new work is served after the current descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| db_we | input | 1 | Doorbell write strobe |
| db_pi | input | IDX_W | New producer index |
| ring_we | input | 1 | Descriptor ring write strobe |
| ring_waddr | input | IDX_W | Descriptor slot to write |
| ring_wdata | input | 128 | Descriptor contents |
| cpl_raddr | input | CPL_IDX_W | Completion ring read slot |
| cpl_rdata | output | 64 | Completion record at cpl_raddr |
| pi_o | output | IDX_W | Current producer index |
| ci_o | output | IDX_W | Current consumer index |
| cpl_wptr_o | output | CPL_IDX_W | Next completion slot to be written |
| ovf_err_o | output | 1 | Sticky error flag for a rejected doorbell |
| exe_valid | output | 1 | Request to executor valid |
| exe_ptr | output | 64 | Command buffer address |
| exe_len | output | 32 | Command buffer length |
| exe_ready | input | 1 | Executor accepts request |
| exe_done | input | 1 | Executor finished the buffer |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The risky overlap is a doorbell write that lands in the cycle where the engine posts a completion and moves its consumer index. The doorbell check and the index update then read the same register on the same edge. The bench drives the doorbell exactly in the completion cycle and requires three things: the new producer index is taken, the error flag stays clear, and the engine goes on to serve the added descriptor. A second overlap, a backward doorbell while a request is stalled on ready, must be rejected without disturbing the held request.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int DESC_W = 128;
  localparam int ADDR_W = 64;
  localparam int LEN_W  = 32;
  localparam int CPL_W  = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_CPL,
    ST_IRQ
  } seq_state_e;

  function automatic logic [ADDR_W-1:0] desc_addr(input logic [DESC_W-1:0] d);
    return d[ADDR_W-1:0];
  endfunction

  function automatic logic [LEN_W-1:0] desc_len(input logic [DESC_W-1:0] d);
    return d[ADDR_W+LEN_W-1:ADDR_W];
  endfunction
endpackage

// File: rtl/cmdq_rst_sync.sv
module cmdq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/cmdq_ring_mem.sv
module cmdq_ring_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cmdq_doorbell.sv
module cmdq_doorbell #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_we,
  input  logic [IDX_W-1:0] db_pi,
  input  logic [IDX_W-1:0] ci,
  output logic [IDX_W-1:0] pi,
  output logic             err
);
  logic [IDX_W-1:0] pending_now, pending_new, pi_d;
  logic             accept, reject, pi_en, err_d;

  always_comb begin
    pending_now = pi - ci;
    pending_new = db_pi - ci;
    accept      = db_we && (pending_new >= pending_now);
    reject      = db_we && !accept;
    pi_en       = accept;
    pi_d        = db_pi;
    err_d       = err | reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pi  <= '0;
      err <= 1'b0;
    end else begin
      if (pi_en) pi <= pi_d;
      err <= err_d;
    end
  end
endmodule

// File: rtl/cmdq_sequencer.sv
module cmdq_sequencer
  import cmdq_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int CPL_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     pi,
  input  logic [DESC_W-1:0]    desc,
  input  logic                 exe_ready,
  input  logic                 exe_done,
  output logic [IDX_W-1:0]     ci,
  output logic [CPL_IDX_W-1:0] cpl_wptr,
  output logic                 cpl_we,
  output logic [CPL_W-1:0]     cpl_wdata,
  output logic                 exe_valid,
  output logic [ADDR_W-1:0]    exe_ptr,
  output logic [LEN_W-1:0]     exe_len,
  output logic                 irq
);
  seq_state_e state_q, state_d;
  logic       load_en, adv_en;

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    adv_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (pi != ci) begin
        load_en = 1'b1;
        state_d = ST_REQ;
      end
      ST_REQ:  if (exe_ready) state_d = ST_WAIT;
      ST_WAIT: if (exe_done)  state_d = ST_CPL;
      ST_CPL: begin
        adv_en  = 1'b1;
        state_d = ST_IRQ;
      end
      ST_IRQ:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ci       <= '0;
      cpl_wptr <= '0;
    end else begin
      state_q <= state_d;
      if (adv_en) begin
        ci       <= ci + 1'b1;
        cpl_wptr <= cpl_wptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      exe_ptr <= desc_addr(desc);
      exe_len <= desc_len(desc);
    end
  end

  assign exe_valid = (state_q == ST_REQ);
  assign irq       = (state_q == ST_IRQ);
  assign cpl_we    = adv_en;
  assign cpl_wdata = {exe_len, 32'(ci)};
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int CPL_DEPTH  = 8,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int CPL_IDX_W = $clog2(CPL_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 db_we,
  input  logic [IDX_W-1:0]     db_pi,
  input  logic                 ring_we,
  input  logic [IDX_W-1:0]     ring_waddr,
  input  logic [DESC_W-1:0]    ring_wdata,
  input  logic [CPL_IDX_W-1:0] cpl_raddr,
  output logic [CPL_W-1:0]     cpl_rdata,
  output logic [IDX_W-1:0]     pi_o,
  output logic [IDX_W-1:0]     ci_o,
  output logic [CPL_IDX_W-1:0] cpl_wptr_o,
  output logic                 ovf_err_o,
  output logic                 exe_valid,
  output logic [ADDR_W-1:0]    exe_ptr,
  output logic [LEN_W-1:0]     exe_len,
  input  logic                 exe_ready,
  input  logic                 exe_done,
  output logic                 irq_o
);
  logic              rst_n_int;
  logic [DESC_W-1:0] cur_desc;
  logic              cpl_we;
  logic [CPL_W-1:0]  cpl_wdata;

  cmdq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  cmdq_ring_mem #(.DEPTH(RING_DEPTH), .WIDTH(DESC_W)) u_desc_ring (
    .clk(clk), .we(ring_we), .waddr(ring_waddr), .wdata(ring_wdata),
    .raddr(ci_o), .rdata(cur_desc)
  );

  cmdq_doorbell #(.IDX_W(IDX_W)) u_db (
    .clk(clk), .rst_n(rst_n_int), .db_we(db_we), .db_pi(db_pi),
    .ci(ci_o), .pi(pi_o), .err(ovf_err_o)
  );

  cmdq_sequencer #(.IDX_W(IDX_W), .CPL_IDX_W(CPL_IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n_int), .pi(pi_o), .desc(cur_desc),
    .exe_ready(exe_ready), .exe_done(exe_done), .ci(ci_o),
    .cpl_wptr(cpl_wptr_o), .cpl_we(cpl_we), .cpl_wdata(cpl_wdata),
    .exe_valid(exe_valid), .exe_ptr(exe_ptr), .exe_len(exe_len), .irq(irq_o)
  );

  cmdq_ring_mem #(.DEPTH(CPL_DEPTH), .WIDTH(CPL_W)) u_cpl_ring (
    .clk(clk), .we(cpl_we), .waddr(cpl_wptr_o), .wdata(cpl_wdata),
    .raddr(cpl_raddr), .rdata(cpl_rdata)
  );
endmodule

// File: rtl/cmdq_engine_chk.sv
module cmdq_engine_chk #(
  parameter int IDX_W     = 3,
  parameter int CPL_IDX_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IDX_W-1:0]     pi_o,
  input logic [IDX_W-1:0]     ci_o,
  input logic [CPL_IDX_W-1:0] cpl_wptr_o,
  input logic                 ovf_err_o,
  input logic                 exe_valid,
  input logic [63:0]          exe_ptr,
  input logic [31:0]          exe_len,
  input logic                 exe_ready,
  input logic                 irq_o
);
  assert_no_req_when_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid |-> (pi_o != ci_o));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && !exe_ready) |=> (exe_valid && $stable(exe_ptr) && $stable(exe_len)));

  assert_cpl_before_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cpl_wptr_o != $past(cpl_wptr_o)));

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_ci_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ci_o) |-> ((ci_o - $past(ci_o)) == IDX_W'(1)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err_o |=> ovf_err_o);
endmodule

bind cmdq_engine cmdq_engine_chk #(.IDX_W(IDX_W), .CPL_IDX_W(CPL_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pi_o(pi_o), .ci_o(ci_o), .cpl_wptr_o(cpl_wptr_o),
  .ovf_err_o(ovf_err_o), .exe_valid(exe_valid), .exe_ptr(exe_ptr),
  .exe_len(exe_len), .exe_ready(exe_ready), .irq_o(irq_o)
);

// File: tb/cmdq_engine_bench.sv
`timescale 1ns/1ps
module cmdq_engine_bench;
  localparam int D = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic db_we = 1'b0;
  logic [IW-1:0] db_pi = '0;
  logic ring_we = 1'b0;
  logic [IW-1:0] ring_waddr = '0;
  logic [127:0] ring_wdata = '0;
  logic [IW-1:0] cpl_raddr = '0;
  logic [63:0] cpl_rdata;
  logic [IW-1:0] pi_o, ci_o, cpl_wptr_o;
  logic ovf_err_o, exe_valid, irq_o;
  logic [63:0] exe_ptr;
  logic [31:0] exe_len;
  logic exe_ready = 1'b0;
  logic exe_done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  cmdq_engine u_cmdq_engine (
    .clk(clk), .rst_n(rst_n), .db_we(db_we), .db_pi(db_pi),
    .ring_we(ring_we), .ring_waddr(ring_waddr), .ring_wdata(ring_wdata),
    .cpl_raddr(cpl_raddr), .cpl_rdata(cpl_rdata), .pi_o(pi_o), .ci_o(ci_o),
    .cpl_wptr_o(cpl_wptr_o), .ovf_err_o(ovf_err_o), .exe_valid(exe_valid),
    .exe_ptr(exe_ptr), .exe_len(exe_len), .exe_ready(exe_ready),
    .exe_done(exe_done), .irq_o(irq_o)
  );

  // stimulus table: {addr[64], len[32], ready stall[8], done delay[8]}
  localparam logic [111:0] VEC [10] = '{
    {64'h0000_0000_1000_0000, 32'h0000_0040, 8'd0, 8'd0},
    {64'h0000_0001_2000_0100, 32'h0000_1000, 8'd2, 8'd1},
    {64'hFFFF_FFFF_FFFF_FFF0, 32'hFFFF_FFFF, 8'd1, 8'd3},
    {64'h0000_0000_0000_0000, 32'h0000_0000, 8'd0, 8'd5},
    {64'h8000_0000_0000_0008, 32'h0000_0010, 8'd4, 8'd0},
    {64'h1234_5678_9ABC_DEF0, 32'h0BAD_F00D, 8'd3, 8'd2},
    {64'h0000_00AA_5500_0000, 32'h0000_0800, 8'd0, 8'd1},
    {64'h0F0F_0F0F_0F0F_0F0F, 32'h8000_0000, 8'd1, 8'd0},
    {64'h0000_0000_CAFE_0000, 32'h0000_0001, 8'd2, 8'd2},
    {64'hA5A5_A5A5_5A5A_5A5A, 32'h0000_7FFF, 8'd0, 8'd4}
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<60000", cycles);
      finish_run();
    end
  end

  task automatic put_desc(input logic [IW-1:0] slot, input logic [63:0] a, input logic [31:0] l);
    ring_we = 1'b1; ring_waddr = slot;
    ring_wdata = {32'hDEAD_0000 | 32'(slot), l, a};
    @(negedge clk);
    ring_we = 1'b0;
  endtask

  task automatic ring_bell(input logic [IW-1:0] v);
    db_we = 1'b1; db_pi = v;
    @(negedge clk);
    db_we = 1'b0;
  endtask

  // serve one request as the executor and check the completion path
  task automatic serve(input logic [63:0] a, input logic [31:0] l, input int rd, input int dd,
                       input logic [IW-1:0] slot, input logic [IW-1:0] wp_after,
                       input bit bell_at_cpl, input logic [IW-1:0] bell_val);
    logic [IW-1:0] ci_hold;
    bit ok;
    while (!exe_valid) @(negedge clk);
    chk(exe_ptr == a, "R3 addr", exe_ptr, a);
    chk(exe_len == l, "R3 len", exe_len, l);
    for (int k = 0; k < rd; k++) begin
      @(negedge clk);
      chk(exe_valid && exe_ptr == a && exe_len == l, "R4 hold", {exe_valid, exe_ptr}, {1'b1, a});
    end
    exe_ready = 1'b1;
    @(negedge clk);
    exe_ready = 1'b0;
    ci_hold = ci_o;
    ok = !exe_valid;
    for (int k = 0; k < dd; k++) begin
      @(negedge clk);
      ok = ok && !irq_o && (ci_o == ci_hold);
    end
    chk(ok && ci_o == slot, "R5 wait for done", ci_o, slot);
    exe_done = 1'b1;
    @(negedge clk);
    exe_done = 1'b0;
    chk(!irq_o, "R7 no irq before record", irq_o, 1'b0);
    if (bell_at_cpl) begin
      db_we = 1'b1; db_pi = bell_val;
    end
    cpl_raddr = wp_after - 1'b1;
    @(negedge clk);
    db_we = 1'b0;
    chk(irq_o, "R7 irq pulse", irq_o, 1'b1);
    chk(cpl_rdata == {l, 32'(slot)}, "R6 record", cpl_rdata, {l, 32'(slot)});
    chk(cpl_wptr_o == wp_after, "R6 wptr", cpl_wptr_o, wp_after);
    chk(ci_o == IW'(slot + 1), "R8 ci advance", ci_o, IW'(slot + 1));
    @(negedge clk);
    chk(!irq_o, "R7 single cycle", irq_o, 1'b0);
  endtask

  initial begin
    logic [IW-1:0] base;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pi_o == 0 && ci_o == 0 && cpl_wptr_o == 0, "R1 indices", {pi_o, ci_o, cpl_wptr_o}, 0);
    chk(!ovf_err_o && !irq_o && !exe_valid, "R1 flags", {ovf_err_o, irq_o, exe_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!exe_valid, "R2 idle when empty", exe_valid, 1'b0);

    // table walk: one descriptor per doorbell, indices wrap (R8, R6)
    for (int i = 0; i < 10; i++) begin
      put_desc(IW'(i), VEC[i][111:48], VEC[i][47:16]);
      ring_bell(IW'(i + 1));
      chk(pi_o == IW'(i + 1), "R2 doorbell", pi_o, IW'(i + 1));
      serve(VEC[i][111:48], VEC[i][47:16], int'(VEC[i][15:8]), int'(VEC[i][7:0]),
            IW'(i), IW'(i + 1), 1'b0, '0);
    end

    // fill to depth-1, reject backward doorbell, serve in order
    base = ci_o;
    for (int j = 0; j < D - 1; j++)
      put_desc(IW'(base + j), 64'h4000 + 64'(j * 16), 32'(100 + j));
    ring_bell(IW'(base + D - 1));
    chk(pi_o == IW'(base + D - 1), "R9 full accepted", pi_o, IW'(base + D - 1));
    chk(!ovf_err_o, "R9 no error at full", ovf_err_o, 1'b0);
    while (!exe_valid) @(negedge clk);
    ring_bell(IW'(base + 1));
    chk(pi_o == IW'(base + D - 1), "R10 ignored", pi_o, IW'(base + D - 1));
    chk(ovf_err_o, "R10 error set", ovf_err_o, 1'b1);
    for (int j = 0; j < D - 1; j++)
      serve(64'h4000 + 64'(j * 16), 32'(100 + j), j % 3, j % 2,
            IW'(base + j), IW'(base + j + 1), 1'b0, '0);
    chk(ovf_err_o, "R10 sticky", ovf_err_o, 1'b1);

    // reset clears all state
    rst_n = 1'b0;
    @(negedge clk);
    chk(pi_o == 0 && ci_o == 0 && cpl_wptr_o == 0 && !ovf_err_o, "R1 reset clears",
        {pi_o, ci_o, cpl_wptr_o, ovf_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // doorbell in the completion cycle
    put_desc(0, 64'h7000, 32'h11);
    put_desc(1, 64'h7100, 32'h22);
    ring_bell(1);
    serve(64'h7000, 32'h11, 1, 1, 0, 1, 1'b1, 2);
    chk(pi_o == 2 && !ovf_err_o, "R11 bell during advance", {pi_o, ovf_err_o}, {3'd2, 1'b0});
    serve(64'h7100, 32'h22, 0, 0, 1, 2, 1'b0, '0);
    repeat (3) @(negedge clk);
    chk(!exe_valid && ci_o == 2, "R2 idle again", {exe_valid, ci_o}, {1'b0, 3'd2});

    // reset in the middle of a request
    put_desc(2, 64'h9000, 32'h33);
    ring_bell(3);
    while (!exe_valid) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!exe_valid && !irq_o && ci_o == 0 && pi_o == 0, "R1 async reset", {exe_valid, ci_o, pi_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!exe_valid, "R2 empty after reset", exe_valid, 1'b0);
    finish_run();
  end
endmodule